// File: doc/BRIEF.md
# Rate-Selectable PID Regulator

This block is a fixed-point proportional-integral-derivative regulator. It drives a signed actuator word from the difference between a setpoint and a measured sample. The difference is scaled down by a programmable arithmetic right shift before any gain is applied. The three gains are unsigned fractions below one. After the three terms are summed, a programmed offset is added, and the result is clamped to the signed output range.

The loop can recompute on every clock. It can also recompute only on strobes from an internal prescaler, which a two-bit code selects. This slows regulation to about 1 MHz, 120 kHz or 15 kHz from a 125 MHz clock. An enable input starts and stops regulation. While the block is stopped, its dynamic state is cleared, its output follows the offset, and new gain words are accepted. While it runs, the gains are frozen.

Top module: `pid_rate_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it is released, `result` and `error` are 0.
- R2: At each update, `error` takes the value (setpoint - meas) arithmetically shifted right by `err_shift` (15-bit signed), and this same value feeds all three terms.
- R3: `skip` selects the update period: 0 = every clock, 1 = every 125 clocks, 2 = every 1042 clocks, 3 = every 8333 clocks. After `enable` rises, the first update occurs on the N-th enabled clock edge, where N is the period. Between updates, `result` and `error` hold.
- R4: At an update, `result` = sat(offset + floor((kp*e + I + kd*(e - e_prev)) / 65536)). Here e is the shifted error, I is the integrator after this update, e_prev is the error from the previous update, and the gains are unsigned 16-bit fractions (value/65536).
- R5: At each update, the integrator adds ki*e. It is kept at full precision and is not rescaled.
- R6: While `enable` is low, the integrator and e_prev are cleared, `error` is 0, and `result` equals the `offset` sampled on the previous clock.
- R7: The gain inputs are captured on every clock while `enable` is low. Changes to them while `enable` is high have no effect on `result`.
- R8: `result` saturates to [-8192, 8191] and never wraps.
- R9: If the previous `result` is 8191 and ki*e > 0, or if it is -8192 and ki*e < 0, the integrator keeps its value at that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (125 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulation on (1) / off (0) |
| meas | input | 14 | Measured sample, signed |
| setpoint | input | 14 | Target value, signed |
| kp | input | 16 | Proportional gain, unsigned fraction |
| ki | input | 16 | Integral gain, unsigned fraction |
| kd | input | 16 | Derivative gain, unsigned fraction |
| err_shift | input | 4 | Right-shift amount applied to the error |
| skip | input | 2 | Update-rate code |
| offset | input | 14 | Value added after the PID sum, signed |
| result | output | 14 | Saturated actuator value, signed |
| error | output | 15 | Shifted error of the last update, signed |

## Verification
Output saturation and integrator accumulation can fall on the same update strobe, and the anti-windup rule decides which of the two wins. The bench provokes this with a near-unity integral gain and a large constant error, so that the output is pinned at the positive limit for one update with the integral still pushing upward. It then reverses the sign of the error. The check is the value on the first update after the reversal. That value must equal the integrator built up before the clamp minus one step, not a value still held at the rail.

// File: rtl/pid_rate_ctrl.sv
module pid_rate_ctrl #(
  parameter int DW   = 14,
  parameter int GW   = 16,
  parameter int SHW  = 4,
  parameter int DIV1 = 125,
  parameter int DIV2 = 1042,
  parameter int DIV3 = 8333
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic signed [DW-1:0] meas,
  input  logic signed [DW-1:0] setpoint,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic [GW-1:0]        kd,
  input  logic [SHW-1:0]       err_shift,
  input  logic [1:0]           skip,
  input  logic signed [DW-1:0] offset,
  output logic signed [DW-1:0] result,
  output logic signed [DW:0]   error
);
  localparam int EW = DW + 1;
  localparam int SW = DW + GW + 6;
  localparam int CW = $clog2(DIV3 + 1);
  localparam logic signed [SW-1:0] OMAX = SW'(2 ** (DW - 1) - 1);
  localparam logic signed [SW-1:0] OMIN = ~OMAX;

  logic [GW-1:0] kp_r, ki_r, kd_r;
  logic [CW-1:0] cnt, lim;
  logic tick;
  logic signed [EW-1:0] e_raw, e, ep;
  logic signed [SW-1:0] e_x, ep_x, kp_x, ki_x, kd_x, res_x, off_x;
  logic signed [SW-1:0] p_t, i_t, d_t, acc, acc_n, sum, u;
  logic signed [DW-1:0] sat;
  logic hold;

  always_comb begin
    case (skip)
      2'd0:    lim = CW'(1);
      2'd1:    lim = CW'(DIV1);
      2'd2:    lim = CW'(DIV2);
      default: lim = CW'(DIV3);
    endcase
  end

  assign tick  = enable && (cnt >= lim - CW'(1));

  assign e_raw = {setpoint[DW-1], setpoint} - {meas[DW-1], meas};
  assign e     = e_raw >>> err_shift;

  assign e_x   = {{(SW-EW){e[EW-1]}}, e};
  assign ep_x  = {{(SW-EW){ep[EW-1]}}, ep};
  assign kp_x  = {{(SW-GW){1'b0}}, kp_r};
  assign ki_x  = {{(SW-GW){1'b0}}, ki_r};
  assign kd_x  = {{(SW-GW){1'b0}}, kd_r};
  assign res_x = {{(SW-DW){result[DW-1]}}, result};
  assign off_x = {{(SW-DW){offset[DW-1]}}, offset};

  assign p_t   = e_x * kp_x;
  assign i_t   = e_x * ki_x;
  assign d_t   = (e_x - ep_x) * kd_x;

  assign hold  = (res_x == OMAX && i_t > 0) || (res_x == OMIN && i_t < 0);
  assign acc_n = hold ? acc : acc + i_t;
  assign sum   = p_t + acc_n + d_t;
  assign u     = off_x + (sum >>> GW);
  assign sat   = (u > OMAX) ? OMAX[DW-1:0] : (u < OMIN) ? OMIN[DW-1:0] : u[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kp_r   <= '0;
      ki_r   <= '0;
      kd_r   <= '0;
      cnt    <= '0;
      acc    <= '0;
      ep     <= '0;
      result <= '0;
      error  <= '0;
    end else if (!enable) begin
      kp_r   <= kp;
      ki_r   <= ki;
      kd_r   <= kd;
      cnt    <= '0;
      acc    <= '0;
      ep     <= '0;
      result <= offset;
      error  <= '0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (tick) begin
        acc    <= acc_n;
        ep     <= e;
        result <= sat;
        error  <= e;
      end
    end
  end
endmodule

// File: rtl/pid_rate_ctrl_props.sv
module pid_rate_ctrl_props #(
  parameter int DW = 14,
  parameter int GW = 16,
  parameter int SW = 36
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 enable,
  input logic [1:0]           skip,
  input logic signed [DW-1:0] offset,
  input logic signed [DW-1:0] result,
  input logic signed [DW:0]   error,
  input logic                 tick,
  input logic [GW-1:0]        kp_r,
  input logic [GW-1:0]        ki_r,
  input logic [GW-1:0]        kd_r,
  input logic signed [SW-1:0] acc
);
  p_idle_offset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> result == $past(offset));

  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (error == '0 && acc == '0));

  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> ($stable(result) && $stable(error)));

  p_full_rate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && skip == 2'd0) |-> tick);

  p_gain_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(kp_r) && $stable(ki_r) && $stable(kd_r)));
endmodule

bind pid_rate_ctrl pid_rate_ctrl_props #(.DW(DW), .GW(GW), .SW(SW)) u_props (
  .clk(clk), .rst_n(rst_n), .enable(enable), .skip(skip), .offset(offset),
  .result(result), .error(error), .tick(tick),
  .kp_r(kp_r), .ki_r(ki_r), .kd_r(kd_r), .acc(acc)
);

// File: tb/pid_rate_ctrl_test.sv
`timescale 1ns/1ps
module pid_rate_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic signed [13:0] meas = '0, setpoint = '0, offset = '0;
  logic [15:0] kp = '0, ki = '0, kd = '0;
  logic [3:0] err_shift = '0;
  logic [1:0] skip = '0;
  logic signed [13:0] result;
  logic signed [14:0] error;

  int checks = 0;
  int errors = 0;

  typedef struct { string tag; int r; int e; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  pid_rate_ctrl uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .meas(meas), .setpoint(setpoint),
    .kp(kp), .ki(ki), .kd(kd), .err_shift(err_shift), .skip(skip),
    .offset(offset), .result(result), .error(error)
  );

  longint m_cnt, m_acc, m_ep, m_res, m_err, m_kp, m_ki, m_kd;
  longint lim, me, ie, s, u;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc = 0; m_ep = 0; m_res = 0; m_err = 0;
      m_kp = 0; m_ki = 0; m_kd = 0;
    end else if (!enable) begin
      m_kp = longint'(kp); m_ki = longint'(ki); m_kd = longint'(kd);
      m_cnt = 0; m_acc = 0; m_ep = 0; m_res = longint'(offset); m_err = 0;
    end else begin
      lim = (skip == 0) ? 1 : (skip == 1) ? 125 : (skip == 2) ? 1042 : 8333;
      if (m_cnt >= lim - 1) begin
        m_cnt = 0;
        me = (longint'(setpoint) - longint'(meas)) >>> err_shift;
        ie = m_ki * me;
        if (!((m_res == 8191 && ie > 0) || (m_res == -8192 && ie < 0)))
          m_acc = m_acc + ie;
        s = m_kp * me + m_acc + m_kd * (me - m_ep);
        u = longint'(offset) + (s >>> 16);
        m_res = (u > 8191) ? 8191 : (u < -8192) ? -8192 : u;
        m_ep = me;
        m_err = me;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic cyc(input string tag);
    item_t it;
    @(posedge clk);
    #1;
    it.tag = tag; it.r = int'(m_res); it.e = int'(m_err);
    q.push_back(it);
  endtask

  task automatic hexp(input string tag, input int r, input int e);
    item_t it;
    it.tag = tag; it.r = r; it.e = e;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (int'(result) != it.r || int'(error) != it.e) begin
        errors++;
        $display("FAIL %s: result=%0d error=%0d expected result=%0d error=%0d",
                 it.tag, result, error, it.r, it.e);
      end
    end
  end

  task automatic direct(input string tag, input int got, input int exp_v);
    checks++;
    if (got != exp_v) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp_v);
    end
  endtask

  task automatic measure(input logic [1:0] code, input int period);
    int n;
    enable = 1'b0; skip = code; kp = 16'h8000; ki = '0; kd = '0;
    setpoint = 14'sd100; meas = '0; offset = '0; err_shift = '0;
    cyc("R3");
    enable = 1'b1;
    n = 0;
    while (error != 15'sd100 && n < 20000) begin cyc("R3"); n++; end
    direct("R3 first update", n, period);
    setpoint = 14'sd200;
    n = 0;
    while (error != 15'sd200 && n < 20000) begin cyc("R3"); n++; end
    direct("R3 second update", n, period);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    direct("R1 result in reset", int'(result), 0);
    direct("R1 error in reset", int'(error), 0);
    rst_n = 1'b1;
    cyc("R1"); hexp("R1", 0, 0);

    offset = 14'sd123;
    cyc("R6"); hexp("R6", 123, 0);

    kp = 16'h8000; setpoint = 14'sd200; meas = '0; offset = 14'sd10;
    cyc("R6");
    enable = 1'b1;
    cyc("R4"); hexp("R4", 110, 200);
    err_shift = 4'd2;
    cyc("R2"); hexp("R2", 35, 50);
    kp = 16'hFFFF;
    cyc("R7"); hexp("R7", 35, 50);
    cyc("R7"); hexp("R7", 35, 50);

    enable = 1'b0; kp = '0; ki = 16'h4000; err_shift = '0;
    setpoint = 14'sd100; offset = '0;
    cyc("R6"); hexp("R6", 0, 0);
    enable = 1'b1;
    cyc("R5"); hexp("R5", 25, 100);
    cyc("R5"); hexp("R5", 50, 100);
    cyc("R5"); hexp("R5", 75, 100);

    enable = 1'b0; ki = '0; kd = 16'h8000;
    cyc("R6"); hexp("R6", 0, 0);
    enable = 1'b1;
    cyc("R4"); hexp("R4", 50, 100);
    cyc("R4"); hexp("R4", 0, 100);
    meas = -14'sd40;
    cyc("R4"); hexp("R4", 20, 140);

    enable = 1'b0; kd = '0; kp = 16'hFFFF;
    setpoint = 14'sd8191; meas = -14'sd8192;
    cyc("R6");
    enable = 1'b1;
    cyc("R8"); hexp("R8", 8191, 16383);
    setpoint = -14'sd8192; meas = 14'sd8191;
    cyc("R8"); hexp("R8", -8192, -16383);
    offset = -14'sd50; setpoint = '0; meas = '0;
    cyc("R4"); hexp("R4", -50, 0);

    enable = 1'b0; kp = '0; ki = 16'hFFFF; offset = '0;
    setpoint = 14'sd8000; meas = '0;
    cyc("R6"); hexp("R6", 0, 0);
    enable = 1'b1;
    cyc("R9"); hexp("R9", 7999, 8000);
    cyc("R9"); hexp("R9", 8191, 8000);
    cyc("R9"); hexp("R9", 8191, 8000);
    setpoint = -14'sd8000;
    cyc("R9"); hexp("R9", 7999, -8000);

    measure(2'd1, 125);
    measure(2'd2, 1042);
    measure(2'd3, 8333);

    enable = 1'b0; offset = -14'sd77;
    cyc("R6"); hexp("R6", -77, 0);
    @(negedge clk);
    #1;
    finish_run();
  end
endmodule